// File: doc/BRIEF.md
# Dual-Source Access Rights Checker

This block stands in front of a group of protected processing units, for example a store of reference images, and decides whether a bus request may reach them. Each request brings a two-bit rights code from the software-driven system bus. A second rights code comes from an independent hardware secure controller that software cannot reach. That second code is set when the system is configured and changes rarely. The request goes through only when both codes are identical and name a real permission. The protected units then receive a read enable, a write enable, or both, exactly as the agreed code allows.

Any admitted request whose codes disagree, or that names no permission, is a violation. A violation blocks the access, raises a sticky alert and advances a saturating violation counter. Only the secure-controller side can clear the alert.

A per-window rate filter stops request floods from software, which would otherwise be a denial-of-service attack. Requests beyond the allowed number within a fixed window of cycles are dropped without further effect. The check is pipelined, so every granted access appears at the protected units exactly one cycle after its request.

Top module: `dual_rights_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, grant, both enables and alert are 0, the violation count is 0, and the forwarded address and data are 0.
- R2: An admitted request whose bus code equals the secure code, with that code not 00, raises grant one cycle later. The rights code uses bit 0 for read and bit 1 for write (00 none, 01 read, 10 write, 11 read and write). In the same cycle as grant, the read enable equals bit 0 and the write enable equals bit 1.
- R3: A bus code of 00 never produces a grant, whatever the secure code is.
- R4: An admitted request whose codes differ, or whose code is 00, drives grant and both enables to 0 one cycle later and sets alert in that same cycle.
- R5: Alert stays set until a cycle with the clear input high and no new violation; if a violation and a clear arrive in the same cycle, alert remains set.
- R6: The violation count rises by exactly one for each violation, never decreases, and holds at its maximum value (all ones) once it gets there.
- R7: Windows of WIN_LEN cycles start at the first cycle after reset and follow each other without gaps. In each window only the first MAX_REQ requests are admitted. Any later request in that window produces no grant, no enable, no alert change and no count change.
- R8: One cycle after a granted request, the forwarded address and data equal the values that came with that request. In every other cycle they are 0.
- R9: A cycle with no request gives grant and enables of 0 in the following cycle, and leaves alert and count unchanged, apart from the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Request strobe from the system bus, one cycle per request |
| bus_rights | input | 2 | Rights code carried by the bus request |
| bus_addr | input | ADDR_W | Address carried by the bus request |
| bus_wdata | input | DATA_W | Write data carried by the bus request |
| sec_rights | input | 2 | Rights code from the secure controller, set at configuration |
| sec_clr | input | 1 | Alert clear from the secure controller |
| grant | output | 1 | Request granted, one cycle after it was made |
| unit_rd_en | output | 1 | Read enable to the protected units |
| unit_wr_en | output | 1 | Write enable to the protected units |
| unit_addr | output | ADDR_W | Address forwarded to the protected units |
| unit_wdata | output | DATA_W | Data forwarded to the protected units |
| alert | output | 1 | Sticky violation flag |
| alert_count | output | CNT_W | Saturating count of violations |

## Verification
The bench drives a request in the same cycle as a clear, to show that the violation wins; a design that let the clear win would lose an attack silently. It sends floods of more than MAX_REQ requests within one window and across a window boundary. A filter that was off by one, or that counted dropped requests, would show up as an extra or a missing grant. A filter that raised an alert on a dropped request would also show up. Requests with both codes at 00 catch a comparator that grants on plain equality. More than fifteen violations check that the count stops at its maximum instead of wrapping to zero.

// File: rtl/rights_pkg.sv
// Shared rights encoding for the dual-source access checker.
// Assumes: bit 0 of a rights code permits reads, bit 1 permits writes.
package rights_pkg;
    localparam int RIGHTS_W = 2;
    typedef enum logic [RIGHTS_W-1:0] {
        RIGHTS_NONE = 2'b00,
        RIGHTS_RD   = 2'b01,
        RIGHTS_WR   = 2'b10,
        RIGHTS_RW   = 2'b11
    } rights_e;
endpackage

// File: rtl/rate_window_filter.sv
// Admits at most MAX_REQ requests per window of WIN_LEN cycles.
// Assumes: windows start at the first cycle after reset and follow back to back;
// dropped requests do not count against the budget.
module rate_window_filter #(
    parameter int WIN_LEN = 64,
    parameter int MAX_REQ = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    output logic admit
);
    localparam int WC_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam int RC_W = $clog2(MAX_REQ + 1);
    localparam logic [WC_W-1:0] WIN_LAST = WC_W'(WIN_LEN - 1);
    localparam logic [RC_W-1:0] REQ_MAX  = RC_W'(MAX_REQ);

    logic [WC_W-1:0] win_cnt;
    logic [RC_W-1:0] req_cnt;
    logic            win_end;

    // Budget check for the current request
    always_comb begin
        admit   = req_in && (req_cnt < REQ_MAX);
        win_end = (win_cnt == WIN_LAST);
    end

    // Cycle position within the window
    always_ff @(posedge clk) begin
        if (!rst_n)       win_cnt <= '0;
        else if (win_end) win_cnt <= '0;
        else              win_cnt <= win_cnt + 1'b1;
    end

    // Admitted requests in the current window
    always_ff @(posedge clk) begin
        if (!rst_n)       req_cnt <= '0;
        else if (win_end) req_cnt <= '0;
        else if (admit)   req_cnt <= req_cnt + 1'b1;
    end
endmodule

// File: rtl/rights_match_check.sv
// Compares the bus rights code against the secure rights code.
// Assumes: only admitted requests are judged; a 00 code never matches.
module rights_match_check
    import rights_pkg::*;
(
    input  logic                admit,
    input  logic [RIGHTS_W-1:0] bus_rights,
    input  logic [RIGHTS_W-1:0] sec_rights,
    output logic                match,
    output logic                violation
);
    // Match and violation decode
    always_comb begin
        match     = admit && (bus_rights == sec_rights) && (bus_rights != RIGHTS_NONE);
        violation = admit && !match;
    end
endmodule

// File: rtl/alert_tracker.sv
// Sticky alert flag and saturating violation counter.
// Assumes: a violation outranks a clear arriving in the same cycle.
module alert_tracker #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             violation,
    input  logic             clr,
    output logic             alert,
    output logic [CNT_W-1:0] alert_count
);
    // Sticky flag: set by violation, cleared only by the secure side
    always_ff @(posedge clk) begin
        if (!rst_n)         alert <= 1'b0;
        else if (violation) alert <= 1'b1;
        else if (clr)       alert <= 1'b0;
    end

    // Violation counter, holds at all ones
    always_ff @(posedge clk) begin
        if (!rst_n)                                alert_count <= '0;
        else if (violation && (alert_count != '1)) alert_count <= alert_count + 1'b1;
    end
endmodule

// File: rtl/dual_rights_gate.sv
// Gate between a system bus and protected units: grants only when the bus
// rights code equals the secure controller code, with rate filtering.
// Assumes: sec_rights is set at configuration; outputs are one cycle after request.
module dual_rights_gate
    import rights_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int WIN_LEN = 64,
    parameter int MAX_REQ = 4,
    parameter int CNT_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic [RIGHTS_W-1:0] bus_rights,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [RIGHTS_W-1:0] sec_rights,
    input  logic                sec_clr,
    output logic                grant,
    output logic                unit_rd_en,
    output logic                unit_wr_en,
    output logic [ADDR_W-1:0]   unit_addr,
    output logic [DATA_W-1:0]   unit_wdata,
    output logic                alert,
    output logic [CNT_W-1:0]    alert_count
);
    logic                admit;
    logic                match;
    logic                violation;
    logic [RIGHTS_W-1:0] en_q;

    rate_window_filter #(.WIN_LEN(WIN_LEN), .MAX_REQ(MAX_REQ)) u_rate (
        .clk(clk), .rst_n(rst_n), .req_in(bus_req), .admit(admit)
    );

    rights_match_check u_cmp (
        .admit(admit), .bus_rights(bus_rights), .sec_rights(sec_rights),
        .match(match), .violation(violation)
    );

    alert_tracker #(.CNT_W(CNT_W)) u_alert (
        .clk(clk), .rst_n(rst_n), .violation(violation), .clr(sec_clr),
        .alert(alert), .alert_count(alert_count)
    );

    // Grant stage register
    always_ff @(posedge clk) begin
        if (!rst_n) grant <= 1'b0;
        else        grant <= match;
    end

    // One enable register per rights bit
    for (genvar b = 0; b < RIGHTS_W; b++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n) en_q[b] <= 1'b0;
            else        en_q[b] <= match && bus_rights[b];
        end
    end

    assign unit_rd_en = en_q[0];
    assign unit_wr_en = en_q[1];

    // Address and data forwarded only on a granted access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_addr  <= '0;
            unit_wdata <= '0;
        end else begin
            unit_addr  <= match ? bus_addr  : '0;
            unit_wdata <= match ? bus_wdata : '0;
        end
    end
endmodule

// File: rtl/rights_gate_checker.sv
// Temporal properties of the dual-source access checker, attached by bind.
// Assumes: observes top-level ports only.
module rights_gate_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic [1:0]       bus_rights,
    input logic [1:0]       sec_rights,
    input logic             sec_clr,
    input logic             grant,
    input logic             unit_rd_en,
    input logic             unit_wr_en,
    input logic             alert,
    input logic [CNT_W-1:0] alert_count
);
    assert_grant_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_rights != sec_rights) |=> !grant);

    assert_none_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_rights == 2'b00) |=> !grant && !unit_rd_en && !unit_wr_en);

    assert_enable_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> !unit_rd_en && !unit_wr_en);

    assert_alert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alert && !sec_clr |=> alert);

    assert_count_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> alert_count >= $past(alert_count));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (alert_count - $past(alert_count)) <= 1);

    assert_idle_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !grant && $stable(alert_count));
endmodule

bind dual_rights_gate rights_gate_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_rights(bus_rights),
    .sec_rights(sec_rights), .sec_clr(sec_clr), .grant(grant),
    .unit_rd_en(unit_rd_en), .unit_wr_en(unit_wr_en), .alert(alert),
    .alert_count(alert_count)
);

// File: tb/dual_rights_gate_tb.sv
// Bench for dual_rights_gate: directed corner cases plus seeded random traffic,
// compared against a cycle model written from the requirements.
module dual_rights_gate_tb;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int WIN_LEN = 16;
    localparam int MAX_REQ = 3;
    localparam int CNT_W   = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic [1:0]        bus_rights = 2'b00;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [1:0]        sec_rights = 2'b00;
    logic              sec_clr = 1'b0;
    logic              grant, unit_rd_en, unit_wr_en, alert;
    logic [ADDR_W-1:0] unit_addr;
    logic [DATA_W-1:0] unit_wdata;
    logic [CNT_W-1:0]  alert_count;

    int checks = 0;
    int errors = 0;

    // model state
    int m_win = 0;
    int m_req = 0;
    int m_cnt = 0;
    bit m_alert = 0;

    always #5ns clk = ~clk;

    dual_rights_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LEN(WIN_LEN),
                       .MAX_REQ(MAX_REQ), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_rights(bus_rights),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sec_rights(sec_rights),
        .sec_clr(sec_clr), .grant(grant), .unit_rd_en(unit_rd_en),
        .unit_wr_en(unit_wr_en), .unit_addr(unit_addr), .unit_wdata(unit_wdata),
        .alert(alert), .alert_count(alert_count)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit admits(input bit req);
        return req && (m_req < MAX_REQ);
    endfunction

    // One cycle: drive at negedge, update model, check at the next negedge
    task automatic step(input bit req, input logic [1:0] br, input logic [1:0] sr,
                        input bit clr, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d);
        bit adm, ok, viol;
        string tag;
        bus_req = req; bus_rights = br; sec_rights = sr; sec_clr = clr;
        bus_addr = a; bus_wdata = d;
        adm  = admits(req);
        ok   = adm && (br == sr) && (br != 2'b00);
        viol = adm && !ok;
        if (viol) m_alert = 1'b1;
        else if (clr) m_alert = 1'b0;
        if (viol && m_cnt != CNT_MAX) m_cnt++;
        if (m_win == WIN_LEN - 1) begin m_win = 0; m_req = 0; end
        else begin m_win++; if (adm) m_req++; end
        if (req && !adm)        tag = "R7";
        else if (req && br == 2'b00) tag = "R3";
        else if (viol)          tag = "R4";
        else if (ok)            tag = "R2";
        else                    tag = "R9";
        @(posedge clk);
        @(negedge clk);
        check(tag, "grant", 64'(grant), 64'(ok));
        check(tag, "rd_en", 64'(unit_rd_en), 64'(ok && br[0]));
        check(tag, "wr_en", 64'(unit_wr_en), 64'(ok && br[1]));
        check("R8", "addr", 64'(unit_addr), ok ? 64'(a) : 64'd0);
        check("R8", "data", 64'(unit_wdata), ok ? 64'(d) : 64'd0);
        check("R5", "alert", 64'(alert), 64'(m_alert));
        check("R6", "count", 64'(alert_count), 64'(m_cnt));
    endtask

    task automatic idle_to_window_start(input logic [1:0] sr);
        while (m_win != 0) step(0, 2'b00, sr, 0, '0, '0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state while reset held
        check("R1", "grant", 64'(grant), 0);
        check("R1", "enables", 64'({unit_rd_en, unit_wr_en}), 0);
        check("R1", "alert", 64'(alert), 0);
        check("R1", "count", 64'(alert_count), 0);
        check("R1", "addr", 64'(unit_addr), 0);
        rst_n = 1'b1;
        // R2 each permission kind on its own
        step(1, 2'b11, 2'b11, 0, 16'h1234, 32'hCAFE0001);
        step(1, 2'b01, 2'b01, 0, 16'h0010, 32'h00000002);
        step(1, 2'b10, 2'b10, 0, 16'hFFFF, 32'hFFFFFFFF);
        idle_to_window_start(2'b01);
        // R4 write requested while secure side allows read only
        step(1, 2'b10, 2'b01, 0, 16'h0AAA, 32'h11111111);
        step(0, 2'b00, 2'b01, 0, '0, '0);           // R5 stays set
        step(0, 2'b00, 2'b01, 1, '0, '0);           // R5 cleared
        // R3 both codes 00
        step(1, 2'b00, 2'b00, 0, 16'h0BBB, 32'h22222222);
        idle_to_window_start(2'b11);
        // R7 flood: five matching requests, last two dropped
        for (int i = 0; i < 5; i++) step(1, 2'b11, 2'b11, 0, 16'(i), 32'(i + 100));
        // R7 a dropped mismatch changes nothing
        step(1, 2'b10, 2'b01, 0, 16'h0CCC, 32'h3);
        idle_to_window_start(2'b11);
        // R5 violation and clear in the same cycle: alert stays
        step(1, 2'b01, 2'b11, 1, 16'h0DDD, 32'h4);
        step(0, 2'b00, 2'b11, 1, '0, '0);
        // R6 saturation: many violations across windows
        for (int w = 0; w < 20; w++) begin
            idle_to_window_start(2'b10);
            step(1, 2'b01, 2'b10, 0, '0, '0);
        end
        // Seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] sr;
            sr = ($urandom % 4 == 0) ? 2'($urandom) : sec_rights;
            step(($urandom % 2) == 0, 2'($urandom), sr, ($urandom % 10) == 0,
                 16'($urandom), 32'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1ms;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule